// File: doc/BRIEF.md
# Multi-Lane Byte Serializer with Loopback and Scan Override

This block turns parallel transmit bytes into serial bit streams, one stream per lane, all driven from a single bit-rate clock. A divide-by-eight counter makes a byte-rate clock from the bit clock. That byte clock is driven out of the block so that upstream logic can launch its transmit bytes on it. On each byte-clock boundary, every lane captures its byte and then shifts it out, most significant bit first, over the next eight bit-clock cycles. An active-low divider reset holds the byte timing at a known phase, so a test environment can line the byte clock up with an outside reference.

On the receive side, each lane picks what it hands to its receiver. It can pass its external serial input pad through unchanged, or feed its own transmit stream back in. A single global switch forces every lane into loopback, whatever the per-lane selects say. For boundary scan, a scan enable replaces the serializer output on every transmit pad with a scan input bit. A registered copy of each receive pad is also provided for observation. All outputs are registered.

Top module: `ser_tx_loop`

## Requirements
- R1: After the divider reset is released, each lane captures its byte on the first bit-clock edge and on every eighth edge after it. The byte appears on `tx_pad` and in loopback on `rx_to_recv` most significant bit first. Bit 7-k is present after edge k+1 (k = 0..7), counting the capture edge as edge 0.
- R2: `tx_byte_clk` has a period of eight bit-clock cycles. It is high after the capture edge and the three edges that follow it, and low after the next four edges.
- R3: While `tx_div_rst_n` is low, `tx_byte_clk` is 0 and the serializer output is 0. The first bit-clock edge at which it is sampled high drives `tx_byte_clk` high and captures the bytes.
- R4: When `loop_all` is 1, every lane's `rx_to_recv` carries its own transmit stream, one cycle after the serializer bit, whatever `loop_sel` holds.
- R5: When `loop_all` is 0, only lanes whose `loop_sel` bit is 1 carry their transmit stream on `rx_to_recv`.
- R6: When `scan_en` is 1, `tx_pad[i]` equals `scan_in[i]` one cycle later. The looped-back stream still comes from the serializer.
- R7: `pad_mon[i]` equals `rx_pad[i]` from the previous bit-clock edge, in every mode.
- R8: A lane that is not in loopback drives `rx_to_recv[i]` with `rx_pad[i]` from the previous edge.
- R9: Synchronous active-high `rst` drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_div_rst_n | input | 1 | Active-low reset of the byte divider and shift registers |
| tx_byte | input | NUM_CH*BYTE_W | Transmit bytes; lane i occupies bits [i*BYTE_W +: BYTE_W] |
| tx_byte_clk | output | 1 | Divided byte clock for launching transmit data |
| scan_en | input | 1 | Scan override of the transmit pads |
| scan_in | input | NUM_CH | Scan values for the transmit pads |
| tx_pad | output | NUM_CH | Serial transmit outputs |
| rx_pad | input | NUM_CH | Serial receive pad inputs |
| loop_all | input | 1 | Global loopback, overrides loop_sel |
| loop_sel | input | NUM_CH | Per-lane loopback select |
| rx_to_recv | output | NUM_CH | Serial stream handed to each receiver |
| pad_mon | output | NUM_CH | Registered copy of the receive pads |

## Verification
Some behaviours are relations that hold from one cycle to the next, and assertions check these on every cycle. They cover the scan override, the pad monitor, the pass-through of non-looped lanes, global and per-lane loopback against the serializer bit, byte capture on the load strobe, and the divider's behaviour while held and on release. Other behaviours need a known stimulus to check. Only the bench scenarios show the bit order of the serial stream, the exact high and low phases of the byte clock, and the handover from one byte to the next. They also show the reset state of the outputs.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic {
    SRC_PAD  = 1'b0,
    SRC_LOOP = 1'b1
  } rx_src_e;
endpackage

// File: rtl/ser_clkdiv.sv
module ser_clkdiv #(
  parameter int BYTE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic div_rst_n,
  output logic byte_clk,
  output logic load
);
  localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] HALF = CW'(BYTE_W / 2);

  logic [CW-1:0] cnt;
  logic          hold;

  assign hold = rst || !div_rst_n;
  assign load = !hold && (cnt == '0);

  always_ff @(posedge clk) begin
    if (hold) begin
      cnt      <= '0;
      byte_clk <= 1'b0;
    end else begin
      cnt      <= (cnt == LAST) ? '0 : cnt + 1'b1;
      byte_clk <= (cnt < HALF);
    end
  end

  p_held_low_r3: assert property (@(posedge clk) disable iff (rst)
    !div_rst_n |=> !byte_clk);
  p_release_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(div_rst_n) |=> byte_clk);
  p_load_rise_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> byte_clk);
endmodule

// File: rtl/ser_lane.sv
module ser_lane
  import ser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              scan_en,
  input  logic              scan_bit,
  input  logic              loop_on,
  input  logic              rx_pad,
  output logic              ser_bit,
  output logic              tx_pad,
  output logic              rx_to_recv,
  output logic              pad_mon
);
  logic [BYTE_W-1:0] shreg;
  rx_src_e           src;

  assign ser_bit = shreg[BYTE_W-1];
  assign src     = loop_on ? SRC_LOOP : SRC_PAD;

  always_ff @(posedge clk) begin
    if (clr)
      shreg <= '0;
    else if (load)
      shreg <= byte_in;
    else
      shreg <= {shreg[BYTE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pad     <= 1'b0;
      rx_to_recv <= 1'b0;
      pad_mon    <= 1'b0;
    end else begin
      tx_pad     <= scan_en ? scan_bit : ser_bit;
      rx_to_recv <= (src == SRC_LOOP) ? ser_bit : rx_pad;
      pad_mon    <= rx_pad;
    end
  end

  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> shreg == $past(byte_in));
  p_scan_r6: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> tx_pad == $past(scan_bit));
  p_monitor_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pad_mon == $past(rx_pad));
  p_passthru_r8: assert property (@(posedge clk) disable iff (rst)
    !loop_on |=> rx_to_recv == $past(rx_pad));
  p_loop_r5: assert property (@(posedge clk) disable iff (rst)
    loop_on |=> rx_to_recv == $past(ser_bit));
endmodule

// File: rtl/ser_tx_loop.sv
module ser_tx_loop #(
  parameter int NUM_CH = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tx_div_rst_n,
  input  logic [NUM_CH*BYTE_W-1:0] tx_byte,
  output logic                     tx_byte_clk,
  input  logic                     scan_en,
  input  logic [NUM_CH-1:0]        scan_in,
  output logic [NUM_CH-1:0]        tx_pad,
  input  logic [NUM_CH-1:0]        rx_pad,
  input  logic                     loop_all,
  input  logic [NUM_CH-1:0]        loop_sel,
  output logic [NUM_CH-1:0]        rx_to_recv,
  output logic [NUM_CH-1:0]        pad_mon
);
  logic              load;
  logic              clr;
  logic [NUM_CH-1:0] ser_bits;
  logic [NUM_CH-1:0] loop_on;

  assign clr     = rst || !tx_div_rst_n;
  assign loop_on = loop_all ? {NUM_CH{1'b1}} : loop_sel;

  ser_clkdiv #(.BYTE_W(BYTE_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .div_rst_n(tx_div_rst_n),
    .byte_clk (tx_byte_clk),
    .load     (load)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
    ser_lane #(.BYTE_W(BYTE_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr),
      .load      (load),
      .byte_in   (tx_byte[i*BYTE_W +: BYTE_W]),
      .scan_en   (scan_en),
      .scan_bit  (scan_in[i]),
      .loop_on   (loop_on[i]),
      .rx_pad    (rx_pad[i]),
      .ser_bit   (ser_bits[i]),
      .tx_pad    (tx_pad[i]),
      .rx_to_recv(rx_to_recv[i]),
      .pad_mon   (pad_mon[i])
    );
  end

  p_loop_all_r4: assert property (@(posedge clk) disable iff (rst)
    loop_all |=> rx_to_recv == $past(ser_bits));
  p_div_clear_r3: assert property (@(posedge clk) disable iff (rst)
    !tx_div_rst_n |=> ser_bits == '0);
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (tx_pad == '0 && rx_to_recv == '0 && pad_mon == '0 && !tx_byte_clk));
endmodule

// File: tb/test_ser_tx_loop.sv
module test_ser_tx_loop;
  localparam int NUM_CH = 4;
  localparam int BYTE_W = 8;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     tx_div_rst_n = 1'b0;
  logic [NUM_CH*BYTE_W-1:0] tx_byte = '0;
  logic                     tx_byte_clk;
  logic                     scan_en = 1'b0;
  logic [NUM_CH-1:0]        scan_in = '0;
  logic [NUM_CH-1:0]        tx_pad;
  logic [NUM_CH-1:0]        rx_pad = '0;
  logic                     loop_all = 1'b0;
  logic [NUM_CH-1:0]        loop_sel = '0;
  logic [NUM_CH-1:0]        rx_to_recv;
  logic [NUM_CH-1:0]        pad_mon;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ser_tx_loop #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) i_ser_tx_loop (
    .clk(clk), .rst(rst), .tx_div_rst_n(tx_div_rst_n), .tx_byte(tx_byte),
    .tx_byte_clk(tx_byte_clk), .scan_en(scan_en), .scan_in(scan_in),
    .tx_pad(tx_pad), .rx_pad(rx_pad), .loop_all(loop_all),
    .loop_sel(loop_sel), .rx_to_recv(rx_to_recv), .pad_mon(pad_mon)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Holds the divider, then sends byte a then byte b on every lane and
  // compares every output after each edge against the expected stream.
  task automatic run_frame(input logic [NUM_CH*BYTE_W-1:0] a,
                           input logic [NUM_CH*BYTE_W-1:0] b,
                           input logic la, input logic [NUM_CH-1:0] ls,
                           input logic se, input logic [NUM_CH-1:0] si,
                           input logic [NUM_CH-1:0] rp);
    logic [NUM_CH-1:0] lp;
    logic [NUM_CH-1:0] sb;
    @(negedge clk);
    tx_div_rst_n = 1'b0;
    loop_all = la; loop_sel = ls; scan_en = se; scan_in = si; rx_pad = rp;
    tx_byte = a;
    lp = la ? {NUM_CH{1'b1}} : ls;
    @(negedge clk);
    @(negedge clk);
    check(tx_byte_clk == 1'b0, "R3 byte clock held", 32'(tx_byte_clk), 0);
    check(tx_pad == (se ? si : '0), "R3 tx held", 32'(tx_pad), 32'(se ? si : '0));
    tx_div_rst_n = 1'b1;
    @(negedge clk);
    check(tx_byte_clk == 1'b1, "R3 first rise", 32'(tx_byte_clk), 1);
    tx_byte = b;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      for (int i = 0; i < NUM_CH; i++) begin
        logic [15:0] s;
        s = {a[i*BYTE_W +: BYTE_W], b[i*BYTE_W +: BYTE_W]};
        sb[i] = s[16 - k];
      end
      check(tx_byte_clk == ((k % 8) < 4), "R2 byte clock phase", 32'(tx_byte_clk),
            32'((k % 8) < 4));
      check(tx_pad == (se ? si : sb), se ? "R6 scan override" : "R1 serial order",
            32'(tx_pad), 32'(se ? si : sb));
      check(rx_to_recv == ((lp & sb) | (~lp & rp)),
            la ? "R4 global loopback" : "R5 R8 lane loopback",
            32'(rx_to_recv), 32'((lp & sb) | (~lp & rp)));
      check(pad_mon == rp, "R7 pad monitor", 32'(pad_mon), 32'(rp));
    end
  endtask

  task automatic t_reset_r9();
    rst = 1'b1;
    tx_div_rst_n = 1'b1;
    rx_pad = '1; scan_en = 1'b1; scan_in = '1;
    repeat (3) @(negedge clk);
    check(tx_pad == '0 && rx_to_recv == '0 && pad_mon == '0 && !tx_byte_clk,
          "R9 reset outputs", 32'({tx_pad, rx_to_recv, pad_mon}), 0);
    rst = 1'b0;
    scan_en = 1'b0; scan_in = '0; rx_pad = '0;
  endtask

  task automatic t_serial_r1();
    run_frame(32'hA55A_C3F0, 32'h0F81_7E24, 1'b0, 4'b0000, 1'b0, 4'b0, 4'b1010);
    run_frame(32'hFF00_8001, 32'h1234_5678, 1'b0, 4'b0000, 1'b0, 4'b0, 4'b0101);
  endtask

  task automatic t_lane_loop_r5();
    run_frame(32'h8A59_E4C9, 32'hE5BF_968A, 1'b0, 4'b0110, 1'b0, 4'b0, 4'b1111);
  endtask

  task automatic t_global_loop_r4();
    run_frame(32'h3C96_69C3, 32'hDEAD_BEEF, 1'b1, 4'b0001, 1'b0, 4'b0, 4'b1001);
  endtask

  task automatic t_scan_r6();
    run_frame(32'h55AA_33CC, 32'h0102_0408, 1'b1, 4'b0000, 1'b1, 4'b1100, 4'b0011);
  endtask

  initial begin
    t_reset_r9();
    t_serial_r1();
    t_lane_loop_r5();
    t_global_loop_r4();
    t_scan_r6();
    t_reset_r9();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule